// File: doc/BRIEF.md
# Indexed Port Bridge

This block is a four-offset byte I/O window that reaches a byte store with a 16-bit address space. A host writes the two address bytes through the first two offsets, then moves data through the data offset. The address register clears itself after every data write, so a loop of data writes always needs the address loaded again. A data read leaves the address as it was, so the same byte can be polled.

Two lock bits each hide a fixed 16-byte window of the store. While a window is hidden, writes into it never reach the store and reads from it return all ones. A separate toggle input flips one lock bit at a time. Addresses at or past the configured store size are treated the same way. The store sits behind a backend port with a combinational read path. A write reaches it as a one-cycle strobe. A read result is registered and shows on the I/O read data one cycle after the read strobe.

Top module: `idx_port_bridge`

## Requirements
- R1: A write to offset 0 loads the low address byte and a write to offset 1 loads the high address byte. The full 16-bit address is visible on `be_addr_o` from the next cycle.
- R2: A write to offset 3 raises `be_we_o` for exactly the cycle of the I/O write, with `be_addr_o` equal to the loaded address and `be_wdata_o` equal to the I/O data. The address is 0x0000 from the next cycle.
- R3: A read from offset 3 puts the store byte at the current address on `io_rdata_o` in the cycle after the read strobe. The address is left unchanged.
- R4: A read from offset 0, 1 or 2 returns 0xFF. A write to offset 2 changes neither the address nor the store.
- R5: While lock bit 0 is set, addresses 0x20 to 0x2F read as 0xFF and ignore writes. Addresses outside that range, such as 0x1F and 0x30, are unaffected.
- R6: While lock bit 1 is set, addresses 0x30 to 0x3F read as 0xFF and ignore writes.
- R7: A pulse on `lock_tgl_i` flips the lock bit selected by `lock_idx_i` (0 or 1). A second pulse with the same index restores access.
- R8: Reset clears the address to 0x0000 and clears both lock bits. `io_rdata_o` resets to 0xFF.
- R9: An address at or above the store size (0x2000 by default) never produces a write strobe and reads as 0xFF.
- R10: `io_rdata_o` holds its last value until the next I/O read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_off_i | input | 2 | I/O window offset |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Registered I/O read data |
| lock_tgl_i | input | 1 | Lock toggle request |
| lock_idx_i | input | 1 | Index of the lock bit to flip |
| be_addr_o | output | 16 | Store address |
| be_wdata_o | output | 8 | Store write data |
| be_we_o | output | 1 | Store write strobe |
| be_re_o | output | 1 | Store read strobe |
| be_rdata_i | input | 8 | Store read data, valid in the cycle of `be_re_o` |

## Verification
A wrong address register shows up on `be_addr_o` in the very next cycle, because that port always drives the register. A missed clear after a data write is therefore visible before any further access. A wrong lock bit stays hidden until the host next touches its window. The bench therefore follows every lock change with a read or write inside the window, at its edges and just outside it. Read-path errors show on `io_rdata_o` one cycle after the read strobe and stay there until the next read.

// File: rtl/idx_bridge_pkg.sv
package idx_bridge_pkg;
  typedef enum logic [1:0] {
    OFF_ADDR_LO = 2'd0,
    OFF_ADDR_HI = 2'd1,
    OFF_RSVD    = 2'd2,
    OFF_DATA    = 2'd3
  } io_off_e;
endpackage

// File: rtl/idx_addr_reg.sv
module idx_addr_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int NBYTES = ADDR_W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBYTES-1:0] byte_we_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           q <= '0;
      else if (clr_i)        q <= '0;
      else if (byte_we_i[b]) q <= wdata_i;
    end
    assign addr_o[b*DATA_W +: DATA_W] = q;

    a_r1_byte_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_we_i[b] && !clr_i) |=> addr_o[b*DATA_W +: DATA_W] == $past(wdata_i));
  end

  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> addr_o == '0);
endmodule

// File: rtl/idx_lock_ctrl.sv
module idx_lock_ctrl #(
  parameter int LOCK_N = 2,
  localparam int LIDX_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgl_i,
  input  logic [LIDX_W-1:0] idx_i,
  output logic [LOCK_N-1:0] lock_o
);
  for (genvar k = 0; k < LOCK_N; k++) begin : g_lock
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= 1'b0;
      else if (tgl_i && (int'(idx_i) == k))     q <= ~q;
    end
    assign lock_o[k] = q;
  end

  a_r7_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgl_i && int'(idx_i) < LOCK_N) |=> lock_o[$past(idx_i)] != $past(lock_o[idx_i]));
endmodule

// File: rtl/idx_access_gate.sv
module idx_access_gate #(
  parameter int ADDR_W     = 16,
  parameter int LOCK_N     = 2,
  parameter int LOCK_BASE  = 32'h20,
  parameter int WIN_SIZE   = 16,
  parameter int STORE_SIZE = 32'h2000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOCK_N-1:0] lock_i,
  output logic              ok_o
);
  logic [31:0]       addr_w;
  logic [LOCK_N-1:0] hit;
  logic              in_range;

  assign addr_w   = 32'(addr_i);
  assign in_range = addr_w < 32'(STORE_SIZE);

  for (genvar k = 0; k < LOCK_N; k++) begin : g_win
    localparam int LO = LOCK_BASE + k * WIN_SIZE;
    localparam int HI = LO + WIN_SIZE;
    assign hit[k] = (addr_w >= 32'(LO)) && (addr_w < 32'(HI));
  end

  assign ok_o = in_range && !(|(hit & lock_i));
endmodule

// File: rtl/idx_port_bridge.sv
module idx_port_bridge
  import idx_bridge_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int LOCK_N     = 2,
  parameter int LOCK_BASE  = 32'h20,
  parameter int WIN_SIZE   = 16,
  parameter int STORE_SIZE = 32'h2000,
  localparam int LIDX_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1,
  localparam int NBYTES = ADDR_W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        io_off_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  input  logic              lock_tgl_i,
  input  logic [LIDX_W-1:0] lock_idx_i,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [DATA_W-1:0] be_wdata_o,
  output logic              be_we_o,
  output logic              be_re_o,
  input  logic [DATA_W-1:0] be_rdata_i
);
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [ADDR_W-1:0] addr_q;
  logic [LOCK_N-1:0] lock_q;
  logic [NBYTES-1:0] byte_we;
  logic              data_wr, data_rd, access_ok;
  logic [DATA_W-1:0] rdata_q;

  assign data_wr = io_wr_i && (io_off_i == OFF_DATA);
  assign data_rd = io_rd_i && (io_off_i == OFF_DATA);

  // offset n loads address byte n; only the two low offsets map to bytes
  for (genvar b = 0; b < NBYTES; b++) begin : g_bsel
    if (b < 2) begin : g_map
      assign byte_we[b] = io_wr_i && (int'(io_off_i) == b);
    end else begin : g_none
      assign byte_we[b] = 1'b0;
    end
  end

  idx_addr_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk_i, .rst_ni,
    .byte_we_i(byte_we),
    .clr_i    (data_wr),
    .wdata_i  (io_wdata_i),
    .addr_o   (addr_q)
  );

  idx_lock_ctrl #(.LOCK_N(LOCK_N)) u_lock (
    .clk_i, .rst_ni,
    .tgl_i (lock_tgl_i),
    .idx_i (lock_idx_i),
    .lock_o(lock_q)
  );

  idx_access_gate #(
    .ADDR_W(ADDR_W), .LOCK_N(LOCK_N), .LOCK_BASE(LOCK_BASE),
    .WIN_SIZE(WIN_SIZE), .STORE_SIZE(STORE_SIZE)
  ) u_gate (
    .addr_i(addr_q),
    .lock_i(lock_q),
    .ok_o  (access_ok)
  );

  assign be_addr_o  = addr_q;
  assign be_wdata_o = io_wdata_i;
  assign be_we_o    = data_wr && access_ok;
  assign be_re_o    = data_rd && access_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= ONES;
    else if (io_rd_i) rdata_q <= be_re_o ? be_rdata_i : ONES;
  end
  assign io_rdata_o = rdata_q;

  a_r3_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !io_wr_i) |=> $stable(be_addr_o));

  a_r4_rsvd_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_off_i != OFF_DATA) |=> io_rdata_o == ONES);

  a_r4_rsvd_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_off_i == OFF_RSVD) |=> $stable(be_addr_o));

  a_r9_we_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_we_o |-> 32'(be_addr_o) < 32'(STORE_SIZE));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |=> $stable(io_rdata_o));

  if (LOCK_N >= 2) begin : g_lock_chk
    a_r5_win0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q[0] && 32'(be_addr_o) >= 32'(LOCK_BASE)
       && 32'(be_addr_o) < 32'(LOCK_BASE + WIN_SIZE)) |-> !be_we_o && !be_re_o);
    a_r6_win1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q[1] && 32'(be_addr_o) >= 32'(LOCK_BASE + WIN_SIZE)
       && 32'(be_addr_o) < 32'(LOCK_BASE + 2*WIN_SIZE)) |-> !be_we_o && !be_re_o);
  end
endmodule

// File: tb/idx_port_bridge_bench.sv
module idx_port_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  io_off = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        lock_tgl = 1'b0;
  logic [0:0]  lock_idx = '0;
  logic [15:0] be_addr;
  logic [7:0]  be_wdata, be_rdata;
  logic        be_we, be_re;

  int total = 0, bad = 0;
  int we_cnt = 0;
  logic [15:0] last_wa = '0;
  logic [7:0]  last_wd = '0;
  logic [7:0]  mem [256];

  always #5 clk = ~clk;

  idx_port_bridge u_idx_port_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .io_off_i(io_off), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .lock_tgl_i(lock_tgl), .lock_idx_i(lock_idx),
    .be_addr_o(be_addr), .be_wdata_o(be_wdata),
    .be_we_o(be_we), .be_re_o(be_re), .be_rdata_i(be_rdata)
  );

  // store model, indexed by the low address byte only
  assign be_rdata = mem[be_addr[7:0]];
  always @(posedge clk) if (be_we) begin
    mem[be_addr[7:0]] <= be_wdata;
    we_cnt  <= we_cnt + 1;
    last_wa <= be_addr;
    last_wd <= be_wdata;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk); io_off = off; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] off, output logic [7:0] v);
    @(negedge clk); io_off = off; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; v = io_rdata;
  endtask

  task automatic do_tgl(input logic i);
    @(negedge clk); lock_idx = i; lock_tgl = 1'b1;
    @(negedge clk); lock_tgl = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    do_wr(2'd0, a[7:0]);
    do_wr(2'd1, a[15:8]);
  endtask

  // {op, off, req, data, exp}; op 0 = write, 1 = read and check, 2 = toggle lock data[0]
  localparam int NV = 34;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'd1, 8'h10, 8'h00},
    {2'd0, 2'd1, 4'd1, 8'h00, 8'h00},
    {2'd0, 2'd3, 4'd2, 8'hA5, 8'h00},
    {2'd0, 2'd0, 4'd1, 8'h10, 8'h00},
    {2'd1, 2'd3, 4'd3, 8'h00, 8'hA5},  // R3 read back
    {2'd1, 2'd3, 4'd3, 8'h00, 8'hA5},  // R3 address kept
    {2'd1, 2'd0, 4'd4, 8'h00, 8'hFF},  // R4
    {2'd0, 2'd0, 4'd1, 8'h25, 8'h00},
    {2'd0, 2'd3, 4'd2, 8'h3C, 8'h00},
    {2'd0, 2'd0, 4'd1, 8'h25, 8'h00},
    {2'd1, 2'd3, 4'd5, 8'h00, 8'h3C},  // R5 unlocked
    {2'd2, 2'd0, 4'd7, 8'h00, 8'h00},
    {2'd0, 2'd0, 4'd1, 8'h25, 8'h00},
    {2'd1, 2'd3, 4'd5, 8'h00, 8'hFF},  // R5 hidden
    {2'd0, 2'd3, 4'd5, 8'h77, 8'h00},  // R5 dropped write
    {2'd2, 2'd0, 4'd7, 8'h00, 8'h00},  // R7 unlock
    {2'd0, 2'd0, 4'd1, 8'h25, 8'h00},
    {2'd1, 2'd3, 4'd7, 8'h00, 8'h3C},
    {2'd0, 2'd0, 4'd1, 8'h2F, 8'h00},
    {2'd0, 2'd3, 4'd2, 8'h81, 8'h00},
    {2'd2, 2'd0, 4'd7, 8'h00, 8'h00},
    {2'd0, 2'd0, 4'd1, 8'h2F, 8'h00},
    {2'd1, 2'd3, 4'd5, 8'h00, 8'hFF},  // R5 top edge
    {2'd0, 2'd0, 4'd1, 8'h1F, 8'h00},
    {2'd0, 2'd3, 4'd5, 8'h66, 8'h00},
    {2'd0, 2'd0, 4'd1, 8'h1F, 8'h00},
    {2'd1, 2'd3, 4'd5, 8'h00, 8'h66},  // R5 below window
    {2'd0, 2'd0, 4'd1, 8'h30, 8'h00},
    {2'd0, 2'd3, 4'd5, 8'h90, 8'h00},
    {2'd0, 2'd0, 4'd1, 8'h30, 8'h00},
    {2'd1, 2'd3, 4'd5, 8'h00, 8'h90},  // R5 above window
    {2'd2, 2'd0, 4'd7, 8'h00, 8'h00},
    {2'd0, 2'd0, 4'd1, 8'h2F, 8'h00},
    {2'd1, 2'd3, 4'd7, 8'h00, 8'h81}   // R7 restored
  };

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 addr", be_addr, 16'h0000);
    check("R8 rdata", {8'h0, io_rdata}, 16'h00FF);
    check("R8 we", {15'h0, be_we}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d vec%0d", e[19:16], i);
      case (e[23:22])
        2'd0: do_wr(e[21:20], e[15:8]);
        2'd1: begin do_rd(e[21:20], v); check(tag, {8'h0, v}, {8'h0, e[7:0]}); end
        default: do_tgl(e[8]);
      endcase
    end

    // R1 address bytes
    set_addr(16'h1234);
    check("R1 full", be_addr, 16'h1234);
    do_wr(2'd0, 8'h56);
    check("R1 low", be_addr, 16'h1256);

    // R2 single strobe and clear
    set_addr(16'h0040);
    c0 = we_cnt;
    do_wr(2'd3, 8'h9A);
    check("R2 one strobe", 16'(we_cnt - c0), 16'd1);
    check("R2 addr", last_wa, 16'h0040);
    check("R2 data", {8'h0, last_wd}, 16'h009A);
    check("R2 clear", be_addr, 16'h0000);

    // R4 offset 2 write ignored, reserved reads
    set_addr(16'h0041);
    c0 = we_cnt;
    do_wr(2'd2, 8'hEE);
    check("R4 addr kept", be_addr, 16'h0041);
    check("R4 no strobe", 16'(we_cnt - c0), 16'd0);
    do_rd(2'd1, v); check("R4 off1", {8'h0, v}, 16'h00FF);
    do_rd(2'd2, v); check("R4 off2", {8'h0, v}, 16'h00FF);

    // R6 window 1
    set_addr(16'h0033); do_wr(2'd3, 8'h11);
    set_addr(16'h0033); do_rd(2'd3, v); check("R6 open", {8'h0, v}, 16'h0011);
    do_tgl(1'b1);
    do_rd(2'd3, v); check("R6 hidden", {8'h0, v}, 16'h00FF);
    c0 = we_cnt;
    do_wr(2'd3, 8'h22);
    check("R6 no strobe", 16'(we_cnt - c0), 16'd0);
    do_tgl(1'b1);
    set_addr(16'h0033); do_rd(2'd3, v); check("R6 kept", {8'h0, v}, 16'h0011);

    // R9 beyond store size
    set_addr(16'h0005); do_wr(2'd3, 8'h5A);
    set_addr(16'h2005);
    c0 = we_cnt;
    do_wr(2'd3, 8'hC3);
    check("R9 no strobe", 16'(we_cnt - c0), 16'd0);
    set_addr(16'h2005); do_rd(2'd3, v); check("R9 read", {8'h0, v}, 16'h00FF);
    set_addr(16'hFFFF); do_rd(2'd3, v); check("R9 top", {8'h0, v}, 16'h00FF);
    set_addr(16'h0005); do_rd(2'd3, v); check("R9 alias", {8'h0, v}, 16'h005A);

    // R10 hold between reads
    do_wr(2'd0, 8'h77);
    repeat (4) @(negedge clk);
    check("R10 hold", {8'h0, io_rdata}, 16'h005A);

    // R8 reset mid-run clears lock and address
    do_tgl(1'b0);
    set_addr(16'h0123);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8 rdata", {8'h0, io_rdata}, 16'h00FF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 addr", be_addr, 16'h0000);
    do_wr(2'd0, 8'h25);
    c0 = we_cnt;
    do_wr(2'd3, 8'h44);
    check("R8 lock cleared", 16'(we_cnt - c0), 16'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule